// File: doc/BRIEF.md
# GPIO Port Register Interface

This block is the register front end of one general-purpose I/O port of up to 32 pins, reached over APB. It stores a per-pin output level and a per-pin output enable, drives them straight to the pad ring, and lets software read the pins back. On that readback each bit is chosen by its own direction. An input pin returns its pad value after a two-flop synchronizer. An output pin returns the level the port is driving.

The same register window holds the interrupt configuration: enable, trigger kind, polarity, dual-edge select, glitch-filter enable and a port-wide level-synchronize bit. These fields go out as plain vectors to a separate interrupt unit. That unit's raw and masked status vectors come back in for software to read. A write to the clear location produces a one-cycle, per-bit clear pulse towards the interrupt unit. Two constant identification words complete the map. Every other location reads as zero.

Top module: `gpio_port_apb`

## Requirements
- R1: After the synchronous active-high reset, all stored registers are zero. So pad_oe and pad_out are zero (every pin an input), irq_clr is zero and prdata is zero.
- R2: The data word at byte offset 0x000 and the direction word at 0x004 read back the last value written. pad_out follows the data word and pad_oe follows the direction word, bit for bit, from the cycle after the write (direction 1 = output, 0 = input).
- R3: The external-port word at 0x050 returns, for each bit, the data-word bit when that direction bit is 1 and the synchronized pad bit when it is 0.
- R4: Pad inputs pass through two synchronizer flops before readback. A read whose setup phase begins in the same cycle as a pad change returns the old pad value. A read started two cycles later returns the new one.
- R5: The interrupt enable (0x030), trigger kind (0x038), polarity (0x03C), glitch-filter enable (0x048) and dual-edge enable (0x068) words read back the last value written. Each also appears on its matching output vector.
- R6: The level-synchronize word at 0x060 keeps only bit 0, which drives irq_lvl_sync. Bits 31:1 read zero.
- R7: A write to 0x04C drives irq_clr with the written bits for exactly the one cycle after the write access. Otherwise irq_clr is zero, and the location reads zero.
- R8: Offset 0x040 returns the irq_masked_st input and offset 0x044 returns the irq_raw_st input.
- R9: Offset 0x064 reads 32'h0000_0001 and offset 0x06C reads 32'h3231_302A.
- R10: Unmapped and reserved offsets (including 0x008) read zero. Writes to read-only or unmapped offsets change no stored register.
- R11: pready is always 1 and pslverr is always 0. A read returns data in its access phase, and a write takes effect at the end of its access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus, the registers and the synchronizer |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access-phase marker |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address within the port window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never an error |
| pad_in | input | N | Raw pad input levels |
| pad_out | output | N | Pad output levels |
| pad_oe | output | N | Pad output enables (1 = drive) |
| irq_en | output | N | Per-pin interrupt enable |
| irq_edge | output | N | Per-pin trigger kind (1 edge, 0 level) |
| irq_pol | output | N | Per-pin polarity (1 high/rising, 0 low/falling) |
| irq_both | output | N | Per-pin dual-edge select |
| irq_dbnc | output | N | Per-pin glitch-filter enable |
| irq_lvl_sync | output | 1 | Synchronize level interrupts |
| irq_clr | output | N | One-cycle per-pin edge clear pulse |
| irq_raw_st | input | N | Raw status from the interrupt unit |
| irq_masked_st | input | N | Masked status from the interrupt unit |

## Verification
The assertions assume the bus follows APB sequencing. penable is never high without psel, and every access phase comes right after a setup phase, so two write accesses are never on adjacent cycles. The clear-pulse and stability properties rely on this. The bench drives the bus only through its read and write tasks. Each task issues one setup cycle and one access cycle, and a new transfer always starts with a fresh setup. Pad and status inputs change only between transfers, or at a setup edge when the synchronizer latency itself is under test.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int APB_AW = 12;
  localparam int APB_DW = 32;
  localparam int WORD_W = APB_AW - 2;

  typedef logic [WORD_W-1:0] word_t;

  // word indexes (byte offset / 4); the map is fixed by software
  localparam word_t W_DOUT   = word_t'(10'h000);
  localparam word_t W_DIR    = word_t'(10'h001);
  localparam word_t W_SRC    = word_t'(10'h002);
  localparam word_t W_IEN    = word_t'(10'h00C);
  localparam word_t W_ITYPE  = word_t'(10'h00E);
  localparam word_t W_IPOL   = word_t'(10'h00F);
  localparam word_t W_MST    = word_t'(10'h010);
  localparam word_t W_RAW    = word_t'(10'h011);
  localparam word_t W_DBNC   = word_t'(10'h012);
  localparam word_t W_CLR    = word_t'(10'h013);
  localparam word_t W_EXT    = word_t'(10'h014);
  localparam word_t W_LSYNC  = word_t'(10'h018);
  localparam word_t W_ID     = word_t'(10'h019);
  localparam word_t W_BOTH   = word_t'(10'h01A);
  localparam word_t W_VER    = word_t'(10'h01B);

  localparam logic [APB_DW-1:0] ID_WORD  = 32'h0000_0001;
  localparam logic [APB_DW-1:0] VER_WORD = 32'h3231_302A;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_cfg.sv
module gpio_port_cfg
  import gpio_port_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  word_t        wr_word,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] dout,
  output logic [N-1:0] dir,
  output logic [N-1:0] ien,
  output logic [N-1:0] itype,
  output logic [N-1:0] ipol,
  output logic [N-1:0] idbnc,
  output logic [N-1:0] iboth,
  output logic         lsync,
  output logic [N-1:0] clr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      dir   <= '0;
      ien   <= '0;
      itype <= '0;
      ipol  <= '0;
      idbnc <= '0;
      iboth <= '0;
      lsync <= 1'b0;
      clr   <= '0;
    end else begin
      clr <= '0;
      if (wr_en) begin
        case (wr_word)
          W_DOUT:  dout  <= wr_bits;
          W_DIR:   dir   <= wr_bits;
          W_IEN:   ien   <= wr_bits;
          W_ITYPE: itype <= wr_bits;
          W_IPOL:  ipol  <= wr_bits;
          W_DBNC:  idbnc <= wr_bits;
          W_BOTH:  iboth <= wr_bits;
          W_LSYNC: lsync <= wr_bits[0];
          W_CLR:   clr   <= wr_bits;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
  import gpio_port_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  word_t             rd_word,
  input  logic [N-1:0]      dout,
  input  logic [N-1:0]      dir,
  input  logic [N-1:0]      ien,
  input  logic [N-1:0]      itype,
  input  logic [N-1:0]      ipol,
  input  logic [N-1:0]      idbnc,
  input  logic [N-1:0]      iboth,
  input  logic              lsync,
  input  logic [N-1:0]      raw_st,
  input  logic [N-1:0]      masked_st,
  input  logic [N-1:0]      pad_sync,
  output logic [APB_DW-1:0] rdata
);
  function automatic logic [APB_DW-1:0] widen(input logic [N-1:0] v);
    logic [APB_DW-1:0] r;
    r = '0;
    r[N-1:0] = v;
    return r;
  endfunction

  logic [N-1:0]      ext_view;
  logic [APB_DW-1:0] rd_nxt;

  // per-bit: outputs show the driven level, inputs show the pad
  assign ext_view = (dir & dout) | (~dir & pad_sync);

  always_comb begin
    case (rd_word)
      W_DOUT:  rd_nxt = widen(dout);
      W_DIR:   rd_nxt = widen(dir);
      W_IEN:   rd_nxt = widen(ien);
      W_ITYPE: rd_nxt = widen(itype);
      W_IPOL:  rd_nxt = widen(ipol);
      W_MST:   rd_nxt = widen(masked_st);
      W_RAW:   rd_nxt = widen(raw_st);
      W_DBNC:  rd_nxt = widen(idbnc);
      W_EXT:   rd_nxt = widen(ext_view);
      W_LSYNC: rd_nxt = {{(APB_DW-1){1'b0}}, lsync};
      W_ID:    rd_nxt = ID_WORD;
      W_BOTH:  rd_nxt = widen(iboth);
      W_VER:   rd_nxt = VER_WORD;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_nxt;
    end
  end
endmodule

// File: rtl/gpio_port_apb.sv
module gpio_port_apb
  import gpio_port_pkg::*;
#(
  parameter int N           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [APB_AW-1:0] paddr,
  input  logic [APB_DW-1:0] pwdata,
  output logic [APB_DW-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [N-1:0]      pad_in,
  output logic [N-1:0]      pad_out,
  output logic [N-1:0]      pad_oe,
  output logic [N-1:0]      irq_en,
  output logic [N-1:0]      irq_edge,
  output logic [N-1:0]      irq_pol,
  output logic [N-1:0]      irq_both,
  output logic [N-1:0]      irq_dbnc,
  output logic              irq_lvl_sync,
  output logic [N-1:0]      irq_clr,
  input  logic [N-1:0]      irq_raw_st,
  input  logic [N-1:0]      irq_masked_st
);
  word_t        word;
  logic         wr_acc;
  logic         rd_setup;
  logic [N-1:0] pad_sync;
  logic [1:0]   unused_addr_lsb;

  assign word            = paddr[APB_AW-1:2];
  assign unused_addr_lsb = paddr[1:0];
  assign wr_acc          = psel & penable & pwrite;
  // read data is captured at the end of setup so it is valid in access
  assign rd_setup        = psel & ~penable & ~pwrite;
  assign pready          = 1'b1;
  assign pslverr         = 1'b0;

  gpio_pad_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pad_sync)
  );

  gpio_port_cfg #(.N(N)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_acc),
    .wr_word (word),
    .wr_bits (pwdata[N-1:0]),
    .dout    (pad_out),
    .dir     (pad_oe),
    .ien     (irq_en),
    .itype   (irq_edge),
    .ipol    (irq_pol),
    .idbnc   (irq_dbnc),
    .iboth   (irq_both),
    .lsync   (irq_lvl_sync),
    .clr     (irq_clr)
  );

  gpio_port_rdmux #(.N(N)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_setup),
    .rd_word   (word),
    .dout      (pad_out),
    .dir       (pad_oe),
    .ien       (irq_en),
    .itype     (irq_edge),
    .ipol      (irq_pol),
    .idbnc     (irq_dbnc),
    .iboth     (irq_both),
    .lsync     (irq_lvl_sync),
    .raw_st    (irq_raw_st),
    .masked_st (irq_masked_st),
    .pad_sync  (pad_sync),
    .rdata     (prdata)
  );
endmodule

// File: rtl/gpio_port_apb_chk.sv
module gpio_port_apb_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         psel,
  input logic         penable,
  input logic         pwrite,
  input logic         pready,
  input logic         pslverr,
  input logic [N-1:0] pad_out,
  input logic [N-1:0] pad_oe,
  input logic         irq_lvl_sync,
  input logic [N-1:0] irq_clr
);
  // R1: one reset cycle leaves outputs cleared
  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && irq_clr == '0));

  // R2: pad drive changes only after a write access
  a_r2_pads_hold: assert property (@(posedge clk) disable iff (rst)
    !(psel && penable && pwrite) |=> ($stable(pad_oe) && $stable(pad_out)));

  // R6: level-sync bit changes only after a write access
  a_r6_lsync_hold: assert property (@(posedge clk) disable iff (rst)
    !(psel && penable && pwrite) |=> $stable(irq_lvl_sync));

  // R7: a clear pulse follows a write access and lasts one cycle
  a_r7_clr_source: assert property (@(posedge clk) disable iff (rst)
    (irq_clr != '0) |-> $past(psel && penable && pwrite));
  a_r7_clr_single: assert property (@(posedge clk) disable iff (rst)
    (irq_clr != '0) |=> (irq_clr == '0));

  // R11: fixed response signals
  a_r11_resp: assert property (@(posedge clk) disable iff (rst)
    pready && !pslverr);
endmodule

bind gpio_port_apb gpio_port_apb_chk #(.N(N)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .psel         (psel),
  .penable      (penable),
  .pwrite       (pwrite),
  .pready       (pready),
  .pslverr      (pslverr),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe),
  .irq_lvl_sync (irq_lvl_sync),
  .irq_clr      (irq_clr)
);

// File: tb/sim_gpio_port_apb.sv
`timescale 1ns/1ps
module sim_gpio_port_apb;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, irq_en, irq_edge, irq_pol, irq_both, irq_dbnc, irq_clr;
  logic        irq_lvl_sync;
  logic [N-1:0] irq_raw_st = '0;
  logic [N-1:0] irq_masked_st = '0;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  gpio_port_apb #(.N(N)) u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_en(irq_en), .irq_edge(irq_edge), .irq_pol(irq_pol),
    .irq_both(irq_both), .irq_dbnc(irq_dbnc), .irq_lvl_sync(irq_lvl_sync),
    .irq_clr(irq_clr), .irq_raw_st(irq_raw_st), .irq_masked_st(irq_masked_st)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all bus tasks start and end 1 ns after a rising edge
  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  // driver: queues the expected word, the monitor compares it
  task automatic apb_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
    end
  endtask

  // monitor: samples read data mid-cycle in the access phase
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R11 unexpected read actual=%h expected=none", prdata);
      end else begin
        chk(tag_q.pop_front(), prdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 irq_clr", irq_clr, 32'h0);
    chk("R1 prdata", prdata, 32'h0);
    chk("R11 pready/pslverr", {30'h0, pready, pslverr}, 32'h2);
    apb_read(12'h004, 32'h0, "R1 dir");
    apb_read(12'h000, 32'h0, "R1 data");

    // R2 data and direction
    apb_write(12'h000, 32'hA5A5_0F0F);
    apb_write(12'h004, 32'hFFFF_0000);
    chk("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    apb_read(12'h000, 32'hA5A5_0F0F, "R2 data readback");
    apb_read(12'h004, 32'hFFFF_0000, "R2 dir readback");

    // R3 mixed direction readback
    pad_in = 32'h1234_5678;
    idle(4);
    apb_read(12'h050, 32'hA5A5_5678, "R3 ext mixed");

    // R4 synchronizer latency: change at the setup edge
    pad_in = 32'h0000_ABCD;
    apb_read(12'h050, 32'hA5A5_5678, "R4 ext old value");
    apb_read(12'h050, 32'hA5A5_ABCD, "R4 ext new value");

    // R3 flipped direction
    apb_write(12'h004, 32'h0000_FFFF);
    apb_read(12'h050, 32'h0000_0F0F, "R3 ext flipped");

    // R5 interrupt configuration
    apb_write(12'h030, 32'h1111_0001);
    apb_write(12'h038, 32'h2222_0002);
    apb_write(12'h03C, 32'h3333_0003);
    apb_write(12'h048, 32'h4444_0004);
    apb_write(12'h068, 32'h5555_0005);
    chk("R5 irq_en", irq_en, 32'h1111_0001);
    chk("R5 irq_edge", irq_edge, 32'h2222_0002);
    chk("R5 irq_pol", irq_pol, 32'h3333_0003);
    chk("R5 irq_dbnc", irq_dbnc, 32'h4444_0004);
    chk("R5 irq_both", irq_both, 32'h5555_0005);
    apb_read(12'h030, 32'h1111_0001, "R5 enable readback");
    apb_read(12'h038, 32'h2222_0002, "R5 type readback");
    apb_read(12'h03C, 32'h3333_0003, "R5 polarity readback");
    apb_read(12'h048, 32'h4444_0004, "R5 filter readback");
    apb_read(12'h068, 32'h5555_0005, "R5 dual-edge readback");

    // R6 level-sync keeps bit 0 only
    apb_write(12'h060, 32'hFFFF_FFFF);
    chk("R6 lvl_sync set", {31'h0, irq_lvl_sync}, 32'h1);
    apb_read(12'h060, 32'h0000_0001, "R6 lsync readback");
    apb_write(12'h060, 32'hFFFF_FFFE);
    chk("R6 lvl_sync cleared", {31'h0, irq_lvl_sync}, 32'h0);

    // R7 clear pulse
    chk("R7 clr idle", irq_clr, 32'h0);
    apb_write(12'h04C, 32'h8000_0081);
    chk("R7 clr pulse", irq_clr, 32'h8000_0081);
    idle(1);
    chk("R7 clr gone", irq_clr, 32'h0);
    apb_read(12'h04C, 32'h0, "R7 clr reads zero");

    // R8 status passthrough
    irq_raw_st = 32'hDEAD_BEEF;
    irq_masked_st = 32'h0000_BEEF;
    apb_read(12'h044, 32'hDEAD_BEEF, "R8 raw");
    apb_read(12'h040, 32'h0000_BEEF, "R8 masked");

    // R9 constants
    apb_read(12'h064, 32'h0000_0001, "R9 id");
    apb_read(12'h06C, 32'h3231_302A, "R9 version");

    // R10 reserved reads and ignored writes
    apb_read(12'h008, 32'h0, "R10 reserved 0x008");
    apb_read(12'h010, 32'h0, "R10 unmapped 0x010");
    apb_read(12'hFFC, 32'h0, "R10 unmapped 0xFFC");
    apb_write(12'h050, 32'hFFFF_FFFF);
    apb_write(12'h064, 32'hFFFF_FFFF);
    apb_write(12'h040, 32'hFFFF_FFFF);
    apb_write(12'h008, 32'hFFFF_FFFF);
    apb_write(12'h07C, 32'hFFFF_FFFF);
    chk("R10 pad_out kept", pad_out, 32'hA5A5_0F0F);
    chk("R10 pad_oe kept", pad_oe, 32'h0000_FFFF);
    chk("R10 irq_en kept", irq_en, 32'h1111_0001);
    chk("R10 clr quiet", irq_clr, 32'h0);
    apb_read(12'h008, 32'h0, "R10 reserved after write");
    apb_read(12'h064, 32'h0000_0001, "R10 id after write");
    apb_read(12'h000, 32'hA5A5_0F0F, "R10 data after writes");

    chk("R11 pready/pslverr end", {30'h0, pready, pslverr}, 32'h2);
    idle(2);
    chk("R11 all reads answered", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule